// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Controller

This block sits between free-running clock sources and the pins that carry them. It turns each CPU clock and each PCI clock output on or off without producing short pulses. Each output has its own enable bit, written by a serial configuration interface. There is also a shared active-low power-down pin. A mode strap chooses whether that pin is honoured. An output runs only when its own bit and the power-down condition both allow it.

Every control input is asynchronous. All of them are brought into the domain of the free-running PCI reference clock. A run request is formed there. Each output then applies that request at the next falling edge of its own source clock. A running output therefore always ends on a complete high phase and stops low. When it starts again, its first high phase is also complete. The free-running PCI reference clock is passed through and is never gated.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A gated output runs only when its serial enable bit is 1 and the power-down condition is inactive. Output order is CPU outputs first, then PCI outputs.
- R2: A stopped output is held at 0, and a gated output is never 1 while its source clock is 0.
- R3: A change of run state takes effect only after SYNC_STAGES+1 rising edges of the PCI reference clock, followed by a falling edge of the gated source. Within two reference cycles of an input change, the old state still holds.
- R4: Every high pulse on a gated output lasts exactly one full high phase of its source clock, so no high phase is truncated or split.
- R5: With mode_i = 1, pd_ni has no effect, and outputs follow their enable bits alone.
- R6: With mode_i = 0 and pd_ni = 0, all gated outputs stop. The reference output pci_f_clk_o keeps running.
- R7: During reset all gated outputs are 0. After release they start through the same synchronized sequence.
- R8: pd_ni may change at any time, unrelated to any clock. Its effect appears after synchronization, and clearing it restarts the outputs that are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pci_f_clk_i | input | 1 | Free-running PCI reference clock; this is the control domain |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | N_CPU | Free-running CPU source clocks |
| pci_clk_i | input | N_PCI | Free-running PCI source clocks |
| cpu_en_i | input | N_CPU | Serial-interface enable bit for each CPU output |
| pci_en_i | input | N_PCI | Serial-interface enable bit for each PCI output |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| mode_i | input | 1 | Strap: 0 means pd_ni is honoured, 1 means pd_ni is ignored |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_f_clk_o | output | 1 | Ungated PCI reference clock |

## Verification
The stimulus covers four kinds of enable pattern, chosen so that per-output errors show up:
- alternating masks, which catch swapped or shifted bits;
- all-on and all-off masks;
- power-down asserted with the strap at 0, which must override every enable;
- power-down asserted with the strap at 1, which must be overridden by the enables.

Every gated output runs against a source with a different period or phase. A pulse-width monitor therefore separates a truncated pulse from a correct one on each output.

Directed cases look at the first two reference cycles after reset release and after a disable. These cases separate synchronized behaviour from immediate gating. A stream of enables that toggle every cycle exercises the glitch protection.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  localparam int unsigned DEF_N_CPU = 2;
  localparam int unsigned DEF_N_PCI = 6;
  localparam int unsigned DEF_SYNC  = 2;

  typedef enum logic {
    PD_PIN_USED   = 1'b0,
    PD_PIN_UNUSED = 1'b1
  } pd_mode_e;
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/stop_req_gen.sv
`timescale 1ns/1ps
module stop_req_gen
  import clk_stop_pkg::*;
#(
  parameter int unsigned N_OUT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] en_i,
  input  logic             pd_n_i,
  input  logic             mode_i,
  output logic [N_OUT-1:0] run_o
);
  logic allow;

  // a strapped-off pin counts as "not powered down"
  assign allow = (pd_mode_e'(mode_i) == PD_PIN_UNUSED) || pd_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= '0;
    else         run_o <= en_i & {N_OUT{allow}};
  end
endmodule

// File: rtl/stop_gate_cell.sv
`timescale 1ns/1ps
module stop_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic on_q;

  // updated on the falling edge only, so the AND never cuts a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_q <= 1'b0;
    else         on_q <= run_i;
  end

  assign clk_o = clk_i & on_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int unsigned N_CPU       = DEF_N_CPU,
  parameter int unsigned N_PCI       = DEF_N_PCI,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             pci_f_clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] cpu_clk_i,
  input  logic [N_PCI-1:0] pci_clk_i,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_PCI-1:0] pci_en_i,
  input  logic             pd_ni,
  input  logic             mode_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_f_clk_o
);
  localparam int unsigned N_OUT  = N_CPU + N_PCI;
  localparam int unsigned SYNC_W = N_OUT + 2;

  logic [N_OUT-1:0]  src_clk;
  logic [N_OUT-1:0]  gated_clk;
  logic [SYNC_W-1:0] ctl_async;
  logic [SYNC_W-1:0] ctl_sync;
  logic [N_OUT-1:0]  run_q;

  assign src_clk   = {pci_clk_i, cpu_clk_i};
  assign ctl_async = {mode_i, pd_ni, pci_en_i, cpu_en_i};

  stop_sync #(
    .WIDTH (SYNC_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (pci_f_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_async),
    .q_o   (ctl_sync)
  );

  stop_req_gen #(
    .N_OUT(N_OUT)
  ) u_req (
    .clk_i (pci_f_clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctl_sync[N_OUT-1:0]),
    .pd_n_i(ctl_sync[N_OUT]),
    .mode_i(ctl_sync[N_OUT+1]),
    .run_o (run_q)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    stop_gate_cell u_cell (
      .clk_i (src_clk[i]),
      .rst_ni(rst_ni),
      .run_i (run_q[i]),
      .clk_o (gated_clk[i])
    );
  end

  assign cpu_clk_o   = gated_clk[N_CPU-1:0];
  assign pci_clk_o   = gated_clk[N_OUT-1:N_CPU];
  assign pci_f_clk_o = pci_f_clk_i;
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk #(
  parameter int unsigned N_CPU = 2,
  parameter int unsigned N_PCI = 6
) (
  input logic                   pci_f_clk_i,
  input logic                   rst_ni,
  input logic [N_CPU-1:0]       cpu_clk_i,
  input logic [N_PCI-1:0]       pci_clk_i,
  input logic [N_CPU-1:0]       cpu_en_i,
  input logic [N_PCI-1:0]       pci_en_i,
  input logic                   pd_ni,
  input logic                   mode_i,
  input logic [N_CPU-1:0]       cpu_clk_o,
  input logic [N_PCI-1:0]       pci_clk_o,
  input logic [N_CPU+N_PCI-1:0] run_i
);
  localparam int unsigned N_OUT = N_CPU + N_PCI;

  logic [N_OUT-1:0] en_all, src_all, out_all;
  logic [2:0]       age_q;
  logic             settled;

  assign en_all  = {pci_en_i, cpu_en_i};
  assign src_all = {pci_clk_i, cpu_clk_i};
  assign out_all = {pci_clk_o, cpu_clk_o};

  always_ff @(posedge pci_f_clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 3'd7)   age_q <= age_q + 3'd1;
  end
  assign settled = (age_q >= 3'd5);

  p_reset_low_r7: assert property (@(posedge pci_f_clk_i)
    !rst_ni |-> (out_all == '0));

  p_out_within_src_r2: assert property (@(posedge pci_f_clk_i) disable iff (!rst_ni)
    (out_all & ~src_all) == '0);

  p_pd_stops_all_r6: assert property (@(posedge pci_f_clk_i) disable iff (!rst_ni)
    (settled && !mode_i && !pd_ni && !$past(mode_i) && !$past(pd_ni)
     && !$past(mode_i, 2) && !$past(pd_ni, 2) && !$past(mode_i, 3) && !$past(pd_ni, 3))
    |-> (run_i == '0));

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    p_en_low_stops_r1: assert property (@(posedge pci_f_clk_i) disable iff (!rst_ni)
      (settled && !en_all[i] && !$past(en_all[i]) && !$past(en_all[i], 2) && !$past(en_all[i], 3))
      |-> !run_i[i]);

    p_strap_ignores_pd_r5: assert property (@(posedge pci_f_clk_i) disable iff (!rst_ni)
      (settled && mode_i && en_all[i] && $past(mode_i) && $past(en_all[i])
       && $past(mode_i, 2) && $past(en_all[i], 2) && $past(mode_i, 3) && $past(en_all[i], 3))
      |-> run_i[i]);
  end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_CPU(N_CPU),
  .N_PCI(N_PCI)
) u_chk (
  .pci_f_clk_i(pci_f_clk_i),
  .rst_ni     (rst_ni),
  .cpu_clk_i  (cpu_clk_i),
  .pci_clk_i  (pci_clk_i),
  .cpu_en_i   (cpu_en_i),
  .pci_en_i   (pci_en_i),
  .pd_ni      (pd_ni),
  .mode_i     (mode_i),
  .cpu_clk_o  (cpu_clk_o),
  .pci_clk_o  (pci_clk_o),
  .run_i      (run_q)
);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
  localparam int N_CPU = 2;
  localparam int N_PCI = 6;
  localparam int N_OUT = N_CPU + N_PCI;

  logic             pci_f_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_CPU-1:0] cpu_src = '0;
  logic [N_PCI-1:0] pci_src;
  logic [N_CPU-1:0] cpu_en = '0;
  logic [N_PCI-1:0] pci_en = '0;
  logic             pd_n = 1'b1;
  logic             mode = 1'b0;
  logic [N_CPU-1:0] cpu_out;
  logic [N_PCI-1:0] pci_out;
  logic             ref_out;
  logic [N_OUT-1:0] all_o, prev_o;

  int checks = 0;
  int fails  = 0;
  int rise_cnt [N_OUT];
  int ref_rises = 0;
  realtime rise_t [N_OUT];
  int width_bad = 0;
  int pulses = 0;

  always #5 pci_f_clk = ~pci_f_clk;
  always #3 cpu_src[0] = ~cpu_src[0];
  always #4 cpu_src[1] = ~cpu_src[1];

  for (genvar k = 0; k < N_PCI; k++) begin : g_pci_src
    logic c = 1'b0;
    initial begin
      #(k + 1);
      forever #5 c = ~c;
    end
    assign pci_src[k] = c;
  end

  clk_stop_ctrl dut (
    .pci_f_clk_i(pci_f_clk),
    .rst_ni     (rst_n),
    .cpu_clk_i  (cpu_src),
    .pci_clk_i  (pci_src),
    .cpu_en_i   (cpu_en),
    .pci_en_i   (pci_en),
    .pd_ni      (pd_n),
    .mode_i     (mode),
    .cpu_clk_o  (cpu_out),
    .pci_clk_o  (pci_out),
    .pci_f_clk_o(ref_out)
  );

  assign all_o = {pci_out, cpu_out};

  function automatic real half_of(int i);
    if (i == 0) return 3.0;
    if (i == 1) return 4.0;
    return 5.0;
  endfunction

  initial begin
    prev_o = '0;
    for (int i = 0; i < N_OUT; i++) begin
      rise_cnt[i] = 0;
      rise_t[i] = 0.0;
    end
  end

  // R4 monitor: every high pulse must equal the source high phase
  always @(all_o) begin
    for (int i = 0; i < N_OUT; i++) begin
      if (all_o[i] && !prev_o[i]) begin
        rise_cnt[i]++;
        rise_t[i] = $realtime;
      end else if (!all_o[i] && prev_o[i]) begin
        pulses++;
        if (($realtime - rise_t[i]) > half_of(i) + 0.01 ||
            ($realtime - rise_t[i]) < half_of(i) - 0.01)
          width_bad++;
      end
    end
    prev_o = all_o;
  end

  always @(posedge ref_out) ref_rises++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic observe(input int n, output logic [N_OUT-1:0] ran, output int refr);
    int snap [N_OUT];
    int rsnap;
    for (int i = 0; i < N_OUT; i++) snap[i] = rise_cnt[i];
    rsnap = ref_rises;
    repeat (n) @(posedge pci_f_clk);
    #1;
    for (int i = 0; i < N_OUT; i++) ran[i] = (rise_cnt[i] - snap[i]) > 0;
    refr = ref_rises - rsnap;
  endtask

  task automatic drive(input logic [N_CPU-1:0] c, input logic [N_PCI-1:0] p, input logic pdv, input logic m);
    @(negedge pci_f_clk);
    cpu_en = c;
    pci_en = p;
    pd_n   = pdv;
    mode   = m;
  endtask

  // {cpu_en[1:0], pci_en[5:0], pd_n, mode}
  localparam logic [9:0] VEC [8] = '{
    10'b11_111111_1_0,
    10'b01_101010_1_0,
    10'b10_010101_1_0,
    10'b11_111111_0_0,
    10'b11_111111_0_1,
    10'b01_000011_0_1,
    10'b00_000000_1_1,
    10'b11_110000_1_0
  };

  initial begin : watchdog
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [N_OUT-1:0] ran, exp;
    int refr;

    // R7: outputs low under reset, reference still toggles (R6)
    cpu_en = '1; pci_en = '1; pd_n = 1'b1; mode = 1'b0;
    observe(3, ran, refr);
    check(ran == '0 && all_o == '0, "R7", ran, '0);
    check(refr > 0, "R6", refr, 1);

    // R3: release, nothing may start in the first two reference cycles
    @(negedge pci_f_clk);
    rst_n = 1'b1;
    observe(2, ran, refr);
    check(ran == '0, "R3", ran, '0);
    observe(6, ran, refr);
    check(ran == '1, "R7", ran, '1);

    // table walk: R1, R5, R6
    for (int v = 0; v < 8; v++) begin
      logic [9:0] w;
      w = VEC[v];
      drive(w[9:8], w[7:2], w[1], w[0]);
      repeat (6) @(posedge pci_f_clk);
      observe(4, ran, refr);
      exp = {w[7:2], w[9:8]} & {N_OUT{w[0] | w[1]}};
      if (w[0] && !w[1])       check(ran == exp, "R5", ran, exp);
      else if (!w[0] && !w[1]) check(ran == exp, "R6", ran, exp);
      else                     check(ran == exp, "R1", ran, exp);
    end

    // R3: disable is not immediate
    drive('1, '1, 1'b1, 1'b0);
    repeat (6) @(posedge pci_f_clk);
    drive('0, '0, 1'b1, 1'b0);
    observe(2, ran, refr);
    check(ran[N_OUT-1:N_CPU] != '0, "R3", ran, 8'hfc);
    repeat (4) @(posedge pci_f_clk);
    observe(4, ran, refr);
    check(ran == '0, "R2", ran, '0);
    for (int s = 0; s < 4; s++) begin
      #2.7;
      check(all_o == '0, "R2", all_o, '0);
    end

    // R8: asynchronous power-down edge, then release
    drive('1, '1, 1'b1, 1'b0);
    repeat (6) @(posedge pci_f_clk);
    #3.3 pd_n = 1'b0;
    repeat (6) @(posedge pci_f_clk);
    observe(4, ran, refr);
    check(ran == '0, "R8", ran, '0);
    check(refr > 0, "R6", refr, 4);
    #2.1 pd_n = 1'b1;
    repeat (6) @(posedge pci_f_clk);
    observe(4, ran, refr);
    check(ran == '1, "R8", ran, '1);

    // R4: enables toggling every cycle must never produce a short pulse
    for (int t = 0; t < 40; t++) begin
      drive(t[1:0] ^ 2'b01, {t[2:0], ~t[2:0]}, ~t[3], 1'b0);
    end
    drive('1, '1, 1'b1, 1'b0);
    repeat (8) @(posedge pci_f_clk);
    check(width_bad == 0 && pulses > 0, "R4", width_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule